// File: doc/BRIEF.md
# Runtime-Configurable Binary Field Reducer

This block takes the double-width product of two binary polynomials and returns its remainder modulo a sparse reduction polynomial whose degree and middle terms arrive as inputs with each request. The polynomial has the shape x^m + x^a + 1 (trinomial) or x^m + x^a + x^b + x^c + 1 (pentanomial). The degree m may be any value up to the hardware width N, and every middle exponent must lie below m/2. One datapath therefore serves every field size up to N, and a smaller field simply leaves the upper lanes at zero.

The reduction splits the product at bit m into a low part and an overflow part. The overflow is XORed back into the low part at offsets 0, a and, in pentanomial mode, b and c. Because all middle exponents are under m/2, a second identical fold is enough to clear any bits left at or above m. The shift amounts are computed from the request, so there is no per-field wiring. Every request resolves in the next cycle, either as a valid residue or as a configuration error.

Top module: `flexShiftReducer`

## Requirements
- R1: One cycle after a request with a legal configuration, `residue` equals the masked product modulo the polynomial given by `fieldM`, `tapA` and (in pentanomial mode) `tapB`, `tapC`, for every m from 3 to N.
- R2: With `pentaMode` = 0 the polynomial is x^m + x^a + 1; the values on `tapB` and `tapC` have no effect on the residue and are not range-checked.
- R3: With `pentaMode` = 1 the polynomial is x^m + x^a + x^b + x^c + 1, and terms that name the same exponent cancel in pairs.
- R4: Product bits at positions 2m−1 and above are ignored.
- R5: Bits of `residue` at positions m and above are zero whenever `outValid` is high.
- R6: `outValid` rises in the cycle after an accepted request and stays high for exactly one cycle per request. A new request may arrive in every cycle.
- R7: A request with m > N or m < 3 raises `cfgError` for one cycle in the next cycle, and `outValid` stays low.
- R8: A request where a tap that is in use is zero or satisfies 2·tap ≥ m raises `cfgError` in the next cycle, and `outValid` stays low.
- R9: `residue` keeps its last value in cycles after an idle cycle or after a rejected request.
- R10: While `rstN` is low and after it is released, `outValid` and `cfgError` are low and `residue` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe for this cycle |
| product | input | 2N−1 | Unreduced polynomial product, bit i = coefficient of x^i |
| fieldM | input | $clog2(N+1) | Field degree m |
| tapA | input | $clog2(N+1) | First middle exponent |
| tapB | input | $clog2(N+1) | Second middle exponent (pentanomial only) |
| tapC | input | $clog2(N+1) | Third middle exponent (pentanomial only) |
| pentaMode | input | 1 | 1 = pentanomial, 0 = trinomial |
| outValid | output | 1 | Residue presented this cycle |
| cfgError | output | 1 | Previous request was rejected |
| residue | output | N | Reduced result, low m bits meaningful |

## Verification
The output register can deliver a finished residue in the same cycle that the next request is being classified, so an accepted request and a rejected one can meet at the block's edge in adjacent cycles. The bench streams requests with no gaps and mixes legal and illegal configurations. Each cycle it compares `outValid`, `cfgError` and `residue` against a model of the request from the cycle before. The model reduces by bitwise long division, so the residue must update exactly when the flags say it should and must hold otherwise.

// File: rtl/flexRedPkg.sv
package flexRedPkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic capture;      // latch a new residue
    logic reject;       // request had an illegal configuration
    logic useOuterTaps; // pentanomial: fold with b and c too
  } redStrobeT;

endpackage

// File: rtl/flexRedFold.sv
// One fold: split at bit m, XOR the overflow back in at each polynomial term.
module flexRedFold #(
  parameter int PW = 565,
  parameter int MW = 9
) (
  input  logic [PW-1:0] foldIn,
  input  logic [MW-1:0] fieldM,
  input  logic [MW-1:0] tapA,
  input  logic [MW-1:0] tapB,
  input  logic [MW-1:0] tapC,
  input  logic          useOuterTaps,
  output logic [PW-1:0] foldOut
);

  logic [PW-1:0] lowPart;
  logic [PW-1:0] highPart;
  logic [PW-1:0] termA;
  logic [PW-1:0] termB;
  logic [PW-1:0] termC;

  always_comb begin
    lowPart  = foldIn & ~({PW{1'b1}} << fieldM);
    highPart = foldIn >> fieldM;
    termA    = highPart << tapA;
    termB    = useOuterTaps ? (highPart << tapB) : '0;
    termC    = useOuterTaps ? (highPart << tapC) : '0;
    foldOut  = lowPart ^ highPart ^ termA ^ termB ^ termC;
  end

endmodule

// File: rtl/flexRedCtrl.sv
// Configuration check and request sequencing.
module flexRedCtrl
  import flexRedPkg::*;
#(
  parameter int N  = 283,
  parameter int MW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [MW-1:0] fieldM,
  input  logic [MW-1:0] tapA,
  input  logic [MW-1:0] tapB,
  input  logic [MW-1:0] tapC,
  input  logic          pentaMode,
  output redStrobeT     strobe,
  output logic          outValid,
  output logic          cfgError
);

  localparam int SW = MW + 1;
  localparam logic [SW-1:0] MAX_DEG = SW'(N);
  localparam logic [SW-1:0] MIN_DEG = SW'(3);

  logic [SW-1:0] degWide;
  logic          degOk;
  logic          aOk;
  logic          bOk;
  logic          cOk;
  logic          cfgOk;

  // A tap is legal when nonzero and 2*tap < m.
  function automatic logic tapLegal(input logic [MW-1:0] tap, input logic [SW-1:0] deg);
    logic [SW-1:0] twice;
    twice = {tap, 1'b0};
    return (tap != '0) && (twice < deg);
  endfunction

  always_comb begin
    degWide = {1'b0, fieldM};
    degOk   = (degWide <= MAX_DEG) && (degWide >= MIN_DEG);
    aOk     = tapLegal(tapA, degWide);
    bOk     = !pentaMode || tapLegal(tapB, degWide);
    cOk     = !pentaMode || tapLegal(tapC, degWide);
    cfgOk   = degOk && aOk && bOk && cOk;

    strobe.capture      = inValid && cfgOk;
    strobe.reject       = inValid && !cfgOk;
    strobe.useOuterTaps = pentaMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      cfgError <= 1'b0;
    end else begin
      outValid <= strobe.capture;
      cfgError <= strobe.reject;
    end
  end

endmodule

// File: rtl/flexRedPath.sv
// Input masking, two cascaded folds, output masking and the result register.
module flexRedPath
  import flexRedPkg::*;
#(
  parameter int N     = 283,
  parameter int MW    = 9,
  parameter int FOLDS = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  redStrobeT       strobe,
  input  logic [2*N-2:0]  product,
  input  logic [MW-1:0]   fieldM,
  input  logic [MW-1:0]   tapA,
  input  logic [MW-1:0]   tapB,
  input  logic [MW-1:0]   tapC,
  output logic [N-1:0]    residue
);

  localparam int PW = 2 * N - 1;
  localparam int SW = MW + 1;

  logic [SW-1:0] keepWidth;
  logic [PW-1:0] stage [FOLDS+1];
  logic [N-1:0]  reduced;

  // Discard product bits at or above 2m-1.
  always_comb begin
    keepWidth = {fieldM, 1'b0} - SW'(1);
    stage[0]  = product & ~({PW{1'b1}} << keepWidth);
  end

  for (genvar g = 0; g < FOLDS; g++) begin : gFold
    flexRedFold #(.PW(PW), .MW(MW)) uFold (
      .foldIn      (stage[g]),
      .fieldM      (fieldM),
      .tapA        (tapA),
      .tapB        (tapB),
      .tapC        (tapC),
      .useOuterTaps(strobe.useOuterTaps),
      .foldOut     (stage[g+1])
    );
  end

  // Keep only the m low coefficients of the final fold.
  always_comb begin
    reduced = stage[FOLDS][N-1:0] & ~({N{1'b1}} << fieldM);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      residue <= '0;
    end else if (strobe.capture) begin
      residue <= reduced;
    end
  end

endmodule

// File: rtl/flexShiftReducer.sv
// Thin top: control plus datapath.
module flexShiftReducer
  import flexRedPkg::*;
#(
  parameter int N = 283,
  localparam int MW = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [2*N-2:0]  product,
  input  logic [MW-1:0]   fieldM,
  input  logic [MW-1:0]   tapA,
  input  logic [MW-1:0]   tapB,
  input  logic [MW-1:0]   tapC,
  input  logic            pentaMode,
  output logic            outValid,
  output logic            cfgError,
  output logic [N-1:0]    residue
);

  redStrobeT strobe;

  flexRedCtrl #(.N(N), .MW(MW)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .fieldM   (fieldM),
    .tapA     (tapA),
    .tapB     (tapB),
    .tapC     (tapC),
    .pentaMode(pentaMode),
    .strobe   (strobe),
    .outValid (outValid),
    .cfgError (cfgError)
  );

  flexRedPath #(.N(N), .MW(MW), .FOLDS(2)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .product(product),
    .fieldM (fieldM),
    .tapA   (tapA),
    .tapB   (tapB),
    .tapC   (tapC),
    .residue(residue)
  );

endmodule

// File: rtl/flexRedChecker.sv
module flexRedChecker #(
  parameter int N = 283,
  localparam int MW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic [MW-1:0] fieldM,
  input logic          outValid,
  input logic          cfgError,
  input logic [N-1:0]  residue
);

  // R6: a result only follows a request one cycle earlier
  assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  // R7 / R8: an error only follows a request one cycle earlier
  assert_error_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> $past(inValid));

  // R8: a rejected request never also produces a result
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && cfgError));

  // R5: no coefficient at or above the requested degree
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((residue >> $past(fieldM)) == '0));

  // R9: residue holds when no result is presented
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(residue));

  // R10: reset clears the flags
  assert_reset_R10: assert property (@(posedge clk)
    $past(!rstN) |-> (!outValid && !cfgError));

endmodule

bind flexShiftReducer flexRedChecker #(.N(N)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .fieldM  (fieldM),
  .outValid(outValid),
  .cfgError(cfgError),
  .residue (residue)
);

// File: tb/tb_flexShiftReducer.sv
module tb_flexShiftReducer;

  localparam int N      = 16;
  localparam int MW     = $clog2(N + 1);
  localparam int PW     = 2 * N - 1;
  localparam int PERIOD = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [PW-1:0] product = '0;
  logic [MW-1:0] fieldM = '0;
  logic [MW-1:0] tapA = '0;
  logic [MW-1:0] tapB = '0;
  logic [MW-1:0] tapC = '0;
  logic          pentaMode = 1'b0;
  logic          outValid;
  logic          cfgError;
  logic [N-1:0]  residue;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic         expValid = 1'b0;
  logic         expErr = 1'b0;
  logic [N-1:0] expRes = '0;
  string        resTag = "R10";
  string        flagTag = "R10";

  always #(PERIOD / 2) clk = ~clk;

  flexShiftReducer #(.N(N)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .product(product),
    .fieldM(fieldM), .tapA(tapA), .tapB(tapB), .tapC(tapC),
    .pentaMode(pentaMode), .outValid(outValid), .cfgError(cfgError),
    .residue(residue)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Reference: bitwise long division by the polynomial.
  function automatic logic [N-1:0] refReduce(input logic [PW-1:0] p, input int m,
      input int a, input int b, input int c, input bit penta);
    logic [PW-1:0] r;
    logic [PW-1:0] poly;
    r = p;
    for (int i = 2 * m - 1; i < PW; i++) r[i] = 1'b0;
    poly = '0;
    poly[m] = 1'b1;
    poly[0] = poly[0] ^ 1'b1;
    poly[a] = poly[a] ^ 1'b1;
    if (penta) begin
      poly[b] = poly[b] ^ 1'b1;
      poly[c] = poly[c] ^ 1'b1;
    end
    for (int i = 2 * m - 2; i >= m; i--)
      if (r[i]) r = r ^ (poly << (i - m));
    return r[N-1:0];
  endfunction

  function automatic bit cfgBad(input int m, input int a, input int b,
                                input int c, input bit penta);
    bit bad;
    bad = (m > N) || (m < 3) || (a == 0) || (2 * a >= m);
    if (penta) bad = bad || (b == 0) || (2 * b >= m) || (c == 0) || (2 * c >= m);
    return bad;
  endfunction

  // Check the previous cycle's outcome, then present a new request.
  task automatic drive(input bit v, input logic [PW-1:0] p, input int m, input int a,
                       input int b, input int c, input bit penta, input string tag);
    bit bad;
    @(negedge clk);
    check(outValid === expValid, flagTag, "outValid", longint'(outValid), longint'(expValid));
    check(cfgError === expErr, flagTag, "cfgError", longint'(cfgError), longint'(expErr));
    check(residue === expRes, resTag, "residue", longint'(residue), longint'(expRes));
    inValid   = v;
    product   = p;
    fieldM    = MW'(m);
    tapA      = MW'(a);
    tapB      = MW'(b);
    tapC      = MW'(c);
    pentaMode = penta;
    bad = cfgBad(m, a, b, c, penta);
    if (v && !bad) begin
      expValid = 1'b1;
      expErr   = 1'b0;
      expRes   = refReduce(p, m, a, b, c, penta);
      resTag   = tag;
      flagTag  = "R6";
    end else if (v) begin
      expValid = 1'b0;
      expErr   = 1'b1;
      resTag   = "R9";
      flagTag  = (m > N || m < 3) ? "R7" : "R8";
    end else begin
      expValid = 1'b0;
      expErr   = 1'b0;
      resTag   = "R9";
      flagTag  = "R6";
    end
  endtask

  function automatic logic [PW-1:0] rnd();
    return PW'({$urandom, $urandom});
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    // R10: flags and residue during reset
    @(negedge clk);
    check(outValid === 1'b0 && cfgError === 1'b0, "R10", "flags in reset",
          longint'({outValid, cfgError}), 0);
    check(residue === '0, "R10", "residue in reset", longint'(residue), 0);
    rstN = 1'b1;

    // R1 R2: every legal trinomial, junk on the unused taps, back to back
    for (int m = 3; m <= N; m++)
      for (int a = 1; 2 * a < m; a++)
        for (int k = 0; k < 4; k++)
          drive(1'b1, rnd(), m, a, int'($urandom % 32), int'($urandom % 32), 1'b0, "R2");

    // R1 R3: pentanomials, including repeated taps that cancel
    for (int m = 3; m <= N; m++)
      for (int k = 0; k < 12; k++) begin
        int h;
        h = (m - 1) / 2;
        drive(1'b1, rnd(), m, 1 + int'($urandom % h), 1 + int'($urandom % h),
              1 + int'($urandom % h), 1'b1, "R3");
      end

    // R1: full-width field with all-ones and single-bit products
    drive(1'b1, {PW{1'b1}}, N, 5, 3, 2, 1'b1, "R1");
    drive(1'b1, PW'(1) << (PW - 1), N, 7, 0, 0, 1'b0, "R1");
    drive(1'b1, PW'(1) << N, N, 5, 3, 1, 1'b1, "R1");

    // R4: only bits above 2m-1 set must reduce to zero
    drive(1'b1, {PW{1'b1}} << 9, 5, 2, 0, 0, 1'b0, "R4");
    drive(1'b1, {PW{1'b1}} << 15, 8, 3, 2, 1, 1'b1, "R4");

    // R7: degree out of range, then a legal request right after
    drive(1'b1, rnd(), N + 1, 2, 0, 0, 1'b0, "R7");
    drive(1'b1, rnd(), 9, 2, 0, 0, 1'b0, "R1");
    drive(1'b1, rnd(), 31, 2, 0, 0, 1'b0, "R7");
    drive(1'b1, rnd(), 2, 0, 0, 0, 1'b0, "R7");

    // R8: bad taps, with R9 holding the residue across them
    drive(1'b1, rnd(), 10, 5, 1, 1, 1'b0, "R8");
    drive(1'b1, rnd(), 10, 0, 1, 1, 1'b0, "R8");
    drive(1'b1, rnd(), 10, 2, 5, 1, 1'b1, "R8");
    drive(1'b1, rnd(), 10, 2, 1, 0, 1'b1, "R8");
    drive(1'b1, rnd(), 10, 2, 7, 0, 1'b0, "R2");

    // R9: idle cycles keep the last residue
    for (int k = 0; k < 4; k++) drive(1'b0, rnd(), 9, 2, 0, 0, 1'b0, "R9");
    drive(1'b1, rnd(), 12, 3, 0, 0, 1'b0, "R1");
    drive(1'b0, '0, 0, 0, 0, 0, 1'b0, "R9");
    drive(1'b0, '0, 0, 0, 0, 0, 1'b0, "R9");

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule